// File: doc/BRIEF.md
# Oversampled serial receiver with break capture

This block turns an asynchronous serial line into characters. It watches the line on each pulse of a strobe that runs at sixteen times the bit rate. A falling edge starts a candidate frame. The receiver confirms the start bit half a bit later. It then takes each data bit, the optional parity bit and the stop bit at its centre. Each finished character goes into a four-entry queue, together with three error marks that belong to that character alone: framing, parity and break.

A surrounding bus block reads the queue through an 8-bit status word and a data port, and removes the head character with a one-cycle read strobe. A line held low through a whole frame is a break. The receiver stores it once, marked as break, and then ignores the line until it has stayed high for half a bit. The status word also carries two transmitter flags. These come in from outside and are passed straight through.

Top module: `uart_rx_break`

## Requirements
- R1: The status word, from bit 7 down to bit 0, is {break, framing error, parity error, overrun, txEmpty, txReady, queue full, data ready}. It reads 0 out of reset when both transmitter inputs are low. Bits 3 and 2 always equal txEmpty and txReady.
- R2: A low line on a tick in idle starts a frame. If the line is high on the 8th tick after that, the frame is abandoned and nothing is stored.
- R3: Data bits are taken LSB first, 16 ticks apart, the first one 16 ticks after the start confirmation. dataBits codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. Unused upper bits of rxData read 0.
- R4: With parityEn high, one parity bit follows the data. parityOdd=0 selects even parity and parityOdd=1 selects odd parity. A mismatch sets the parity error bit (status bit 5) of that character.
- R5: The stop level is sampled once, 16 ticks after the last data or parity sample. A low level there sets the framing error bit (status bit 6). The next start can be seen on the following tick.
- R6: A character whose data bits are all zero and whose stop sample is low is stored once, with break (bit 7) and framing error (bit 6) set and data 0. No new frame starts until the line has been high on 8 consecutive ticks.
- R7: The queue holds 4 characters. Data ready (bit 0) is high while it is not empty. readStb pops the head. rxData and bits 7..5 show the head, and read 0 while the queue is empty.
- R8: Queue full (bit 1) is high with 4 entries stored. A character that completes while the queue is full, with no pop in the same cycle, is dropped and sets overrun (bit 4). Overrun stays set until clearOe, and a new overrun wins over clearOe in the same cycle.
- R9: Without a tick, a readStb or a clearOe, the queue, the overrun bit and rxData keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial line, already synchronous to clk |
| dataBits | input | 2 | Character length code (5 to 8 bits) |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even |
| txEmpty | input | 1 | Transmitter empty flag, passed to status bit 3 |
| txReady | input | 1 | Transmitter ready flag, passed to status bit 2 |
| readStb | input | 1 | Pops the head character |
| clearOe | input | 1 | Clears the overrun bit |
| rxData | output | 8 | Head character, zero-extended |
| status | output | 8 | Status word |

## Verification
Assertions check the following on every cycle:
- Queue full implies data ready.
- The head flags and data are blank while the queue is empty.
- Break always comes with framing error.
- Overrun stays set until it is cleared.
- Data ready only falls after a read.
- Nothing moves in a cycle without a tick, a read or a clear.

The sampling points, the bit order, the parity polarity, the single break entry with its half-bit quiet period, and dropping a fifth character all depend on whole frames on the line. Only the bench's scenarios, checked against a queue-based reference model, can show these.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int MAX_BITS = 8;
  localparam int IDX_W = $clog2(MAX_BITS);

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             clrShift;
    logic             capBit;
    logic [IDX_W-1:0] bitIdx;
    logic             capPar;
    logic             push;
    logic             stopSeen;
  } rxStrobes_t;

  typedef struct packed {
    logic                rb;
    logic                fe;
    logic                pe;
    logic [MAX_BITS-1:0] data;
  } rxEntry_t;
endpackage

// File: rtl/uart_rx_ctrl.sv
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] dataBits,
  input  logic       parityEn,
  input  logic       dataZero,
  output rxStrobes_t stb
);
  localparam int CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVS / 2 - 1);

  typedef enum logic [2:0] {IDLE, START, DATA, PARITY, STOP, BRKWAIT} rxState_t;

  rxState_t state, nState;
  logic [CNT_W-1:0] cnt, nCnt;
  logic [IDX_W-1:0] bitIdx, nIdx;
  logic [IDX_W-1:0] lastIdx;

  assign lastIdx = IDX_W'(dataBits) + IDX_W'(4);

  always_comb begin
    stb    = '0;
    nState = state;
    nCnt   = cnt;
    nIdx   = bitIdx;
    if (tick) begin
      unique case (state)
        IDLE: if (!rxd) begin
          nState       = START;
          nCnt         = '0;
          stb.clrShift = 1'b1;
        end
        START: if (cnt == HALF_LAST) begin
          nCnt   = '0;
          nIdx   = '0;
          nState = rxd ? IDLE : DATA;
        end else nCnt = cnt + 1'b1;
        DATA: if (cnt == FULL_LAST) begin
          stb.capBit = 1'b1;
          stb.bitIdx = bitIdx;
          nCnt       = '0;
          if (bitIdx == lastIdx) nState = parityEn ? PARITY : STOP;
          else nIdx = bitIdx + 1'b1;
        end else nCnt = cnt + 1'b1;
        PARITY: if (cnt == FULL_LAST) begin
          stb.capPar = 1'b1;
          nCnt       = '0;
          nState     = STOP;
        end else nCnt = cnt + 1'b1;
        STOP: if (cnt == FULL_LAST) begin
          stb.push     = 1'b1;
          stb.stopSeen = rxd;
          nCnt         = '0;
          nState       = (!rxd && dataZero) ? BRKWAIT : IDLE;
        end else nCnt = cnt + 1'b1;
        BRKWAIT: if (!rxd) nCnt = '0;
        else if (cnt == HALF_LAST) nState = IDLE;
        else nCnt = cnt + 1'b1;
        default: nState = IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= nState;
      cnt    <= nCnt;
      bitIdx <= nIdx;
    end
  end
endmodule

// File: rtl/uart_rx_dpath.sv
module uart_rx_dpath
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxd,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       readStb,
  input  logic       clearOe,
  input  rxStrobes_t stb,
  output logic       dataZero,
  output rxEntry_t   headEntry,
  output logic       ffull,
  output logic       rxRdy,
  output logic       oe
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [MAX_BITS-1:0] shreg;
  logic parBit;
  rxEntry_t mem [DEPTH];
  rxEntry_t newEntry;
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic full, popEn, pushEn, ovf;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shreg  <= '0;
      parBit <= 1'b0;
    end else begin
      if (stb.clrShift) shreg <= '0;
      else if (stb.capBit) shreg[stb.bitIdx] <= rxd;
      if (stb.capPar) parBit <= rxd;
    end
  end

  assign dataZero = (shreg == '0);

  always_comb begin
    newEntry.data = shreg;
    newEntry.fe   = !stb.stopSeen;
    newEntry.rb   = !stb.stopSeen && dataZero;
    newEntry.pe   = parityEn && ((^shreg ^ parBit) != parityOdd);
  end

  assign full   = (count == CNT_W'(DEPTH));
  assign popEn  = readStb && (count != '0);
  assign pushEn = stb.push && (!full || popEn);
  assign ovf    = stb.push && full && !readStb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      oe    <= 1'b0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (pushEn) begin
        mem[wrPtr] <= newEntry;
        wrPtr      <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
      end
      if (popEn) rdPtr <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
      case ({pushEn, popEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (ovf) oe <= 1'b1;
      else if (clearOe) oe <= 1'b0;
    end
  end

  assign rxRdy     = (count != '0);
  assign ffull     = full;
  assign headEntry = rxRdy ? mem[rdPtr] : '0;
endmodule

// File: rtl/uart_rx_break.sv
module uart_rx_break
  import uart_rx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int OVERSAMPLE = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tick16,
  input  logic                rxd,
  input  logic [1:0]          dataBits,
  input  logic                parityEn,
  input  logic                parityOdd,
  input  logic                txEmpty,
  input  logic                txReady,
  input  logic                readStb,
  input  logic                clearOe,
  output logic [MAX_BITS-1:0] rxData,
  output logic [7:0]          status
);
  rxStrobes_t stb;
  rxEntry_t   head;
  logic dataZero, ffull, rxRdy, oe;

  uart_rx_ctrl #(.OVS(OVERSAMPLE)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick16), .rxd(rxd), .dataBits(dataBits),
    .parityEn(parityEn), .dataZero(dataZero), .stb(stb)
  );

  uart_rx_dpath #(.DEPTH(FIFO_DEPTH)) dpath_i (
    .clk(clk), .rstN(rstN), .rxd(rxd), .parityEn(parityEn), .parityOdd(parityOdd),
    .readStb(readStb), .clearOe(clearOe), .stb(stb), .dataZero(dataZero),
    .headEntry(head), .ffull(ffull), .rxRdy(rxRdy), .oe(oe)
  );

  assign rxData = head.data;
  assign status = {head.rb, head.fe, head.pe, oe, txEmpty, txReady, ffull, rxRdy};
endmodule

// File: rtl/uart_rx_break_chk.sv
module uart_rx_break_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tick16,
  input logic       readStb,
  input logic       clearOe,
  input logic [7:0] rxData,
  input logic [7:0] status
);
  // R8
  full_needs_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[1] |-> status[0]);

  // R7
  empty_blank_chk: assert property (@(posedge clk) disable iff (!rstN)
    !status[0] |-> (status[7:5] == 3'b000) && (rxData == 8'h00));

  // R6
  break_has_fe_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[7] |-> status[6]);

  // R8
  oe_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(status[4]) && !$past(clearOe) |-> status[4]);

  // R7
  ready_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(status[0]) |-> $past(readStb));

  // R9
  quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(tick16) && !$past(readStb) && !$past(clearOe) |->
      $stable(status[7:4]) && $stable(status[1:0]) && $stable(rxData));
endmodule

bind uart_rx_break uart_rx_break_chk chk_i (.*);

// File: tb/uart_rx_break_tb_top.sv
module uart_rx_break_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, tick16 = 1'b0, rxd = 1'b1;
  logic [1:0] dataBits = 2'd3;
  logic parityEn = 1'b0, parityOdd = 1'b0, txEmpty = 1'b0, txReady = 1'b0;
  logic readStb = 1'b0, clearOe = 1'b0;
  logic [7:0] rxData, status;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  uart_rx_break dut_i (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // tick generator: one pulse every 4 clocks
  int tc = 0;
  always @(negedge clk) begin
    tc     <= (tc == 3) ? 0 : tc + 1;
    tick16 <= (tc == 3);
  end

  // behavioural reference model
  int q[$];
  int mMode = 0, mTk = 0, mHc = 0, n, k, ent;
  logic [7:0] mBits = '0;
  bit mPar = 0, mOe = 0, fe, rb, pe, doPush;

  always @(posedge clk) begin
    if (!rstN) begin
      q.delete(); mMode = 0; mOe = 0;
    end else begin
      doPush = 0;
      n = int'(dataBits) + 5;
      if (tick16) begin
        case (mMode)
          0: if (!rxd) begin mMode = 1; mTk = 0; mBits = '0; end
          1: begin
            mTk++;
            if (mTk == 8 && rxd) mMode = 0;
            else if (mTk > 8 && (mTk - 8) % 16 == 0) begin
              k = (mTk - 8) / 16;
              if (k <= n) mBits[k-1] = rxd;
              else if (parityEn && k == n + 1) mPar = rxd;
              else begin
                fe = !rxd;
                rb = fe && (mBits == 0);
                pe = parityEn && ((^mBits ^ mPar) != parityOdd);
                ent = (int'(rb) << 10) | (int'(fe) << 9) | (int'(pe) << 8) | int'(mBits);
                doPush = 1;
                mMode = rb ? 2 : 0;
                mHc = 0;
              end
            end
          end
          default: if (rxd) begin mHc++; if (mHc == 8) mMode = 0; end else mHc = 0;
        endcase
      end
      if (readStb && q.size() > 0) void'(q.pop_front());
      if (clearOe) mOe = 0;
      if (doPush) begin
        if (q.size() < 4) q.push_back(ent);
        else mOe = 1;
      end
    end
  end

  // compare with model every clock
  always begin
    @(posedge clk);
    #2;
    if (rstN && !finished) begin
      automatic int h = (q.size() > 0) ? q[0] : 0;
      chk("R7 ready", status[0], q.size() > 0);
      chk("R8 full", status[1], q.size() == 4);
      chk("R8 overrun", status[4], mOe);
      chk("R1 tx bits", status[3:2], {txEmpty, txReady});
      chk("R3 data", rxData, h & 32'hFF);
      chk("R4 pe", status[5], (h >> 8) & 1);
      chk("R5 fe", status[6], (h >> 9) & 1);
      chk("R6 rb", status[7], (h >> 10) & 1);
    end
  end

  task automatic holdTicks(int t);
    repeat (4 * t) @(negedge clk);
  endtask

  task automatic sendFrame(logic [7:0] d, int nb, bit pEn, bit pBit, bit stopLvl);
    rxd = 1'b0; holdTicks(16);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; holdTicks(16); end
    if (pEn) begin rxd = pBit; holdTicks(16); end
    rxd = stopLvl; holdTicks(16);
    rxd = 1'b1; holdTicks(16);
  endtask

  task automatic popExpect(logic [7:0] d, logic [2:0] fl, string tag);
    chk(tag, {status[0], status[7:5], rxData}, {1'b1, fl, d});
    readStb = 1'b1;
    @(negedge clk);
    readStb = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    chk("R7 reset data", rxData, 8'h00);
    rstN = 1'b1; txEmpty = 1'b1;
    @(negedge clk);
    chk("R1 passthrough", status, 8'h08);

    // R3 8-bit no parity
    sendFrame(8'hA5, 8, 0, 0, 1);
    popExpect(8'hA5, 3'b000, "R3 8-bit char");
    chk("R7 empty after pop", status[0], 1'b0);

    // R4 7-bit parity, even then odd
    dataBits = 2'd2; parityEn = 1'b1; parityOdd = 1'b0;
    sendFrame(8'h35, 7, 1, 1, 1);
    sendFrame(8'h35, 7, 1, 0, 1);
    parityOdd = 1'b1;
    sendFrame(8'h35, 7, 1, 1, 1);
    popExpect(8'h35, 3'b001, "R4 even mismatch");
    popExpect(8'h35, 3'b000, "R4 even match");
    popExpect(8'h35, 3'b000, "R4 odd match");

    // R5 5-bit framing error
    dataBits = 2'd0; parityEn = 1'b0; parityOdd = 1'b0;
    sendFrame(8'h1F, 5, 0, 0, 0);
    popExpect(8'h1F, 3'b010, "R5 framing error 5-bit");

    // R2 false start
    rxd = 1'b0; holdTicks(3); rxd = 1'b1; holdTicks(20);
    chk("R2 false start ignored", status[0], 1'b0);

    // R6 break with glitch before quiet period ends
    dataBits = 2'd3;
    rxd = 1'b0; holdTicks(480);
    chk("R6 single break entry", {status[1], status[7]}, 2'b01);
    rxd = 1'b1; holdTicks(4);
    rxd = 1'b0; holdTicks(4);
    rxd = 1'b1; holdTicks(12);
    sendFrame(8'h3C, 8, 0, 0, 1);
    popExpect(8'h00, 3'b110, "R6 break entry");
    popExpect(8'h3C, 3'b000, "R6 char after break");
    chk("R6 nothing else stored", status[0], 1'b0);

    // R8 overrun
    sendFrame(8'h11, 8, 0, 0, 1);
    sendFrame(8'h22, 8, 0, 0, 1);
    sendFrame(8'h33, 8, 0, 0, 1);
    sendFrame(8'h44, 8, 0, 0, 1);
    sendFrame(8'h55, 8, 0, 0, 1);
    chk("R8 full and overrun", {status[4], status[1]}, 2'b11);
    popExpect(8'h11, 3'b000, "R8 keep first");
    popExpect(8'h22, 3'b000, "R8 keep second");
    popExpect(8'h33, 3'b000, "R8 keep third");
    popExpect(8'h44, 3'b000, "R8 keep fourth");
    chk("R8 overrun sticky", status[4:0], 5'b11000);
    clearOe = 1'b1; @(negedge clk); clearOe = 1'b0;
    chk("R8 overrun cleared", status[4], 1'b0);

    // R9 idle stability
    txEmpty = 1'b0; txReady = 1'b1;
    holdTicks(10);
    chk("R9 idle status", status, 8'h04);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog R9 actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule